// File: doc/BRIEF.md
# Top-of-memory chip select and low-segment indicator

This block watches every bus cycle's 20-bit physical address and drives two active-low outputs. The first, `csel_top_n`, selects a memory device mapped at the top of the address space. That window always ends at FFFFFh, and software sets its size by writing a size code. The second, `low_seg_n`, goes low for any access whose four upper address bits are all zero, which is the segment that holds the interrupt vector table.

The decode runs only on the clock where `cyc_start` is high. The results are registered and held until `cyc_end`, so a change of the address in mid-cycle cannot glitch either output. After reset the window is 64 Kbytes, F0000h to FFFFFh, so the first instruction fetch at FFFF0h is selected without any setup. While `bus_hold` is high, the chip select stays inactive.

Top module: `top_cs_decoder`

## Requirements
- R1: After reset both outputs are high and the window size code is 0 (64 Kbytes).
- R2: Size codes on `cfg_size` are 0=64K, 1=128K, 2=256K, 3=512K. A write with `cfg_we` high and a code of 4..7 leaves the stored size unchanged.
- R3: The window base is 100000h minus the size. An address at or above the base selects the window.
- R4: On a `cyc_start` clock the decode is registered. Both outputs take their new values on the next clock and hold them through the clock on which `cyc_end` is sampled high.
- R5: When `cyc_end` is sampled high and no `cyc_start` occurs on the same clock, both outputs are high from the next clock on.
- R6: `low_seg_n` is low for the cycle when `addr[19:16]` is 0000.
- R7: Whenever `bus_hold` is high, `csel_top_n` is high on the same clock (combinational gating).
- R8: A change of `addr` while a cycle is in progress does not change either output.
- R9: A size write takes effect on the first `cyc_start` after the write clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 20 | Physical address of the bus cycle |
| cyc_start | input | 1 | High on the first clock of a bus cycle |
| cyc_end | input | 1 | High on the last clock of a bus cycle |
| bus_hold | input | 1 | Bus granted to another master |
| cfg_we | input | 1 | Write strobe for the size code |
| cfg_size | input | 3 | Size code to write |
| csel_top_n | output | 1 | Active-low top-region chip select |
| low_seg_n | output | 1 | Active-low low-segment indicator |

## Verification
On every clock the assertions check these properties:
- the hold gating of the chip select;
- both outputs high outside a cycle;
- an output that stays stable while a cycle continues;
- a size register that changes only on a legal write.

The bench scenarios are needed for the rest:
- the address arithmetic of the window edges for each size (for example EFFFFh against F0000h at 64K, and 80000h at 512K);
- the default window after reset;
- that a rejected code keeps the old size, shown through a later decode.

// File: rtl/top_cs_pkg.sv
package top_cs_pkg;
    localparam int ADDR_W   = 20;
    localparam int SIZE_W   = 3;
    localparam int MIN_LOG2 = 16;
    localparam int NUM_SIZES = 4;
    localparam int SEG_W    = 4;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [1:0]        size_code_t;

    typedef struct packed {
        logic top_hit;
        logic low_hit;
    } decode_t;

    function automatic logic size_code_ok(input logic [SIZE_W-1:0] c);
        return c < SIZE_W'(NUM_SIZES);
    endfunction

    function automatic addr_t window_base(input size_code_t c);
        logic [ADDR_W:0] span;
        span = (ADDR_W+1)'(1) << (MIN_LOG2 + int'(c));
        return addr_t'(((ADDR_W+1)'(1) << ADDR_W) - span);
    endfunction
endpackage

// File: rtl/cs_size_reg.sv
module cs_size_reg
    import top_cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [SIZE_W-1:0] wdata,
    output size_code_t        code
);
    always_ff @(posedge clk) begin
        if (rst)
            code <= '0;
        else if (we && size_code_ok(wdata))
            code <= size_code_t'(wdata);
    end

    a_r2_legal_only: assert property (@(posedge clk) disable iff (rst)
        !$stable(code) |-> ($past(we) && $past(wdata) < SIZE_W'(NUM_SIZES)));
endmodule

// File: rtl/cs_addr_decode.sv
module cs_addr_decode
    import top_cs_pkg::*;
(
    input  addr_t      addr,
    input  size_code_t code,
    output decode_t    dec
);
    addr_t base;
    always_comb begin
        base        = window_base(code);
        dec.top_hit = addr >= base;
        dec.low_hit = addr[ADDR_W-1 -: SEG_W] == '0;
    end
endmodule

// File: rtl/cs_cycle_hold.sv
module cs_cycle_hold
    import top_cs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    cyc_start,
    input  logic    cyc_end,
    input  decode_t dec_in,
    output decode_t dec_q,
    output logic    active
);
    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            dec_q  <= '0;
        end else if (cyc_start) begin
            active <= 1'b1;
            dec_q  <= dec_in;
        end else if (cyc_end) begin
            active <= 1'b0;
            dec_q  <= '0;
        end
    end

    a_r5_idle_clear: assert property (@(posedge clk) disable iff (rst)
        !active |-> dec_q == '0);
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (rst)
        ($past(active) && !$past(cyc_start) && !$past(cyc_end)) |-> $stable(dec_q));
endmodule

// File: rtl/top_cs_decoder.sv
module top_cs_decoder
    import top_cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [19:0]       addr,
    input  logic              cyc_start,
    input  logic              cyc_end,
    input  logic              bus_hold,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_size,
    output logic              csel_top_n,
    output logic              low_seg_n
);
    size_code_t code;
    decode_t    dec_now, dec_q;
    logic       active;

    cs_size_reg u_size (
        .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_size), .code(code)
    );

    cs_addr_decode u_dec (
        .addr(addr), .code(code), .dec(dec_now)
    );

    cs_cycle_hold u_hold (
        .clk(clk), .rst(rst), .cyc_start(cyc_start), .cyc_end(cyc_end),
        .dec_in(dec_now), .dec_q(dec_q), .active(active)
    );

    assign csel_top_n = !(dec_q.top_hit && !bus_hold);
    assign low_seg_n  = !dec_q.low_hit;

    a_r7_hold_blocks: assert property (@(posedge clk) disable iff (rst)
        bus_hold |-> csel_top_n);
    a_r5_idle_high: assert property (@(posedge clk) disable iff (rst)
        !active |-> (csel_top_n && low_seg_n));
    a_r6_low_seg: assert property (@(posedge clk) disable iff (rst)
        (cyc_start && addr[19:16] == 4'h0) |=> !low_seg_n);
endmodule

// File: tb/test_top_cs_decoder.sv
module test_top_cs_decoder;
    localparam int CLK_PERIOD = 10;

    logic clk = 0, rst = 1;
    logic [19:0] addr = '0;
    logic cyc_start = 0, cyc_end = 0, bus_hold = 0, cfg_we = 0;
    logic [2:0] cfg_size = '0;
    logic csel_top_n, low_seg_n;
    int total = 0, bad = 0;
    int model_code = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    top_cs_decoder i_top_cs_decoder (.*);

    function automatic logic exp_cs(input logic [19:0] a, input int c);
        return !(a >= 20'(32'h100000 - (32'h10000 << c)));
    endfunction
    function automatic logic exp_low(input logic [19:0] a);
        return !(a[19:16] == 4'h0);
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic write_size(input logic [2:0] s);
        @(negedge clk); cfg_we = 1; cfg_size = s;
        @(negedge clk); cfg_we = 0;
        if (s < 4) model_code = s;
    endtask

    // drive a cycle of len clocks, checking outputs during it (R4, R6, R8)
    task automatic run_cycle(input logic [19:0] a, input int len, input string tag);
        @(negedge clk); addr = a; cyc_start = 1;
        @(negedge clk); cyc_start = 0;
        for (int i = 0; i < len; i++) begin
            check({tag, " R4 cs"}, csel_top_n, exp_cs(a, model_code));
            check({tag, " R6 low"}, low_seg_n, exp_low(a));
            addr = $urandom;  // R8: address wanders mid-cycle
            if (i == len-1) cyc_end = 1;
            @(negedge clk);
        end
        cyc_end = 0;
        check({tag, " R5 cs idle"}, csel_top_n, 1'b1);
        check({tag, " R5 low idle"}, low_seg_n, 1'b1);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 0;
        check("R1 cs", csel_top_n, 1'b1);
        check("R1 low", low_seg_n, 1'b1);
        run_cycle(20'hFFFF0, 2, "R1 reset vector");
        run_cycle(20'hF0000, 1, "R3 base64");
        run_cycle(20'hEFFFF, 1, "R3 below64");
        run_cycle(20'h0ABCD, 3, "R6 lowseg");
        run_cycle(20'h10000, 1, "R6 not low");
        write_size(3'd3);
        run_cycle(20'h80000, 2, "R9 512 base");
        run_cycle(20'h7FFFF, 1, "R3 below512");
        write_size(3'd6);
        run_cycle(20'h80000, 1, "R2 rejected code");
        write_size(3'd1);
        run_cycle(20'hE0000, 1, "R2 128K");
        run_cycle(20'hDFFFF, 1, "R2 below128");
        // R7: bus hold blocks select during a hitting cycle
        @(negedge clk); addr = 20'hFFFFF; cyc_start = 1;
        @(negedge clk); cyc_start = 0;
        check("R7 before hold", csel_top_n, 1'b0);
        bus_hold = 1; #1;
        check("R7 hold", csel_top_n, 1'b1);
        @(negedge clk); bus_hold = 0; #1;
        check("R7 released", csel_top_n, 1'b0);
        cyc_end = 1; @(negedge clk); cyc_end = 0;
        check("R5 after hold", csel_top_n, 1'b1);
        // random
        for (int k = 0; k < 200; k++) begin
            if ($urandom_range(0, 3) == 0) write_size(3'($urandom_range(0, 7)));
            run_cycle(20'($urandom), $urandom_range(1, 4), "rand R3");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        bad++; total++;
        $display("FAIL watchdog R4 actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule